// File: doc/BRIEF.md
# Registered-Mode Output Macrocell

This block is one output cell of a programmable sum-of-products device that runs in its registered global configuration. The AND array supplies eight product terms to the cell. The cell ORs them and then either stores the sum in a D register clocked by the shared device clock, or passes it straight through as a combinational I/O. Two per-cell architecture bits set the cell's behaviour. One picks between the registered and the combinational form. The other picks active-high or active-low output polarity.

In the registered form, all eight terms feed the register. The pin is enabled by the shared active-low output-enable pin, and the stored state returns to the array as feedback. In the combinational form, term 0 is taken out of the sum and becomes this pin's own active-high output enable. The other seven terms make the data, and the array sees whatever level is on the pin. The register is cleared by the synchronous power-on reset. A test preload strobe can also load it from an eight-bit bus, and the cell takes the bit of that bus selected by its own index. The preload replaces the normal capture for that cycle.

Top module: `olmc_reg_cell`

## Requirements
- R1: One clock edge with `rst` high clears the stored state. In the registered form, the cell then shows `fb_out` = 0, and `pin_out` = 1 when `act_high` is 0 or `pin_out` = 0 when `act_high` is 1.
- R2: In the registered form, at an edge with `rst` and `preload_en` both low, the stored state takes the OR of all eight bits of `pterm`, including bit 0.
- R3: In the registered form, `pin_out` equals the stored state when `act_high` is 1 and its complement when `act_high` is 0.
- R4: In the registered form, `pin_oe` is the inverse of `oe_pin_n`, and `pterm[0]` has no effect on it.
- R5: In the registered form, `fb_out` equals the stored state, before polarity is applied.
- R6: In the combinational form (`comb_sel` = 1), in the same cycle, `pin_out` equals the OR of `pterm[7:1]`, inverted when `act_high` is 0. Bit 0 never reaches the data.
- R7: In the combinational form, `pin_oe` equals `pterm[0]`, and `oe_pin_n` has no effect on it.
- R8: In the combinational form, `fb_out` equals the external pin level `pin_in`.
- R9: At an edge with `preload_en` high and `rst` low, the stored state takes `preload_bus[CELL_IDX]`, whatever the product terms are. With the default CELL_IDX of 3, this is bit 3.
- R10: At an edge where `rst` and `preload_en` are both high, the stored state is cleared and the preload value is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared device clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| comb_sel | input | 1 | Architecture bit: 0 for registered output, 1 for combinational I/O |
| act_high | input | 1 | Architecture bit: 1 for an active-high output, 0 for an active-low output |
| pterm | input | NUM_TERMS | Product terms from the AND array; bit 0 is the enable term in the combinational form |
| oe_pin_n | input | 1 | Shared active-low output-enable pin |
| pin_in | input | 1 | Level seen on the external pin |
| preload_en | input | 1 | Test preload strobe |
| preload_bus | input | PRELOAD_W | Preload value for all cells; this cell uses bit CELL_IDX |
| pin_out | output | 1 | Data driven toward the pin |
| pin_oe | output | 1 | Active-high enable of the pin driver |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
The assertions assume that every input carries a known level at each rising edge. They also assume that reset is held for the first edge, so the stored state starts from a defined value. The bench changes all inputs only on the falling edge, including the architecture bits, and it starts with two reset edges. Mode and polarity changes therefore never meet a clock edge half-applied. The stimulus includes a strobe that arrives during reset, walking single-term patterns, preloads that disagree with the product-term sum, and a combinational phase in which only term 0 is set. It also includes a long mixed random phase.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic {
        CELL_REGISTERED    = 1'b0,
        CELL_COMBINATIONAL = 1'b1
    } cell_kind_e;

    typedef struct packed {
        cell_kind_e kind;
        logic       act_high;
    } cell_arch_t;

    typedef struct packed {
        logic data;
        logic enable;
        logic feedback;
    } pin_drive_t;

    function automatic logic apply_polarity(input logic value, input logic act_high);
        return act_high ? value : ~value;
    endfunction

endpackage

// File: rtl/olmc_term_sum.sv
module olmc_term_sum
    import olmc_pkg::*;
#(
    parameter int NUM_TERMS = 8,
    parameter int OE_TERM   = 0
) (
    input  logic [NUM_TERMS-1:0] pterm,
    output logic                 sum_all,
    output logic                 sum_data,
    output logic                 oe_term
);
    localparam int IDX_W = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1;

    logic [NUM_TERMS-1:0] data_terms;

    // Every term except the one reserved for output enable
    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_mask
        if (g == OE_TERM) begin : g_oe
            assign data_terms[g] = 1'b0;
        end else begin : g_data
            assign data_terms[g] = pterm[g];
        end
    end

    assign sum_all  = |pterm;
    assign sum_data = |data_terms;
    assign oe_term  = pterm[IDX_W'(OE_TERM)];

endmodule

// File: rtl/olmc_state_reg.sv
module olmc_state_reg
    import olmc_pkg::*;
#(
    parameter int PRELOAD_W = 8,
    parameter int CELL_IDX  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 d,
    input  logic                 preload_en,
    input  logic [PRELOAD_W-1:0] preload_bus,
    output logic                 q
);
    localparam int SEL_W = (PRELOAD_W > 1) ? $clog2(PRELOAD_W) : 1;

    logic preload_bit;
    assign preload_bit = preload_bus[SEL_W'(CELL_IDX)];

    // Reset wins over preload, preload wins over capture
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= preload_bit;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/olmc_pin_mux.sv
module olmc_pin_mux
    import olmc_pkg::*;
(
    input  cell_arch_t arch,
    input  logic       q,
    input  logic       sum_data,
    input  logic       oe_term,
    input  logic       oe_pin_n,
    input  logic       pin_in,
    output pin_drive_t drive
);
    always_comb begin
        unique case (arch.kind)
            CELL_REGISTERED: begin
                drive.data     = apply_polarity(q, arch.act_high);
                drive.enable   = ~oe_pin_n;
                drive.feedback = q;
            end
            CELL_COMBINATIONAL: begin
                drive.data     = apply_polarity(sum_data, arch.act_high);
                drive.enable   = oe_term;
                drive.feedback = pin_in;
            end
            default: begin
                drive = '0;
            end
        endcase
    end

endmodule

// File: rtl/olmc_reg_cell.sv
module olmc_reg_cell
    import olmc_pkg::*;
#(
    parameter int NUM_TERMS = 8,
    parameter int PRELOAD_W = 8,
    parameter int CELL_IDX  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 comb_sel,
    input  logic                 act_high,
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 oe_pin_n,
    input  logic                 pin_in,
    input  logic                 preload_en,
    input  logic [PRELOAD_W-1:0] preload_bus,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_out
);
    localparam int OE_TERM = 0;

    cell_arch_t arch;
    pin_drive_t drive;
    logic       sum_all;
    logic       sum_data;
    logic       oe_term;
    logic       q_state;

    assign arch.kind     = comb_sel ? CELL_COMBINATIONAL : CELL_REGISTERED;
    assign arch.act_high = act_high;

    olmc_term_sum #(
        .NUM_TERMS (NUM_TERMS),
        .OE_TERM   (OE_TERM)
    ) u_sum (
        .pterm    (pterm),
        .sum_all  (sum_all),
        .sum_data (sum_data),
        .oe_term  (oe_term)
    );

    olmc_state_reg #(
        .PRELOAD_W (PRELOAD_W),
        .CELL_IDX  (CELL_IDX)
    ) u_state (
        .clk         (clk),
        .rst         (rst),
        .d           (sum_all),
        .preload_en  (preload_en),
        .preload_bus (preload_bus),
        .q           (q_state)
    );

    olmc_pin_mux u_mux (
        .arch     (arch),
        .q        (q_state),
        .sum_data (sum_data),
        .oe_term  (oe_term),
        .oe_pin_n (oe_pin_n),
        .pin_in   (pin_in),
        .drive    (drive)
    );

    assign pin_out = drive.data;
    assign pin_oe  = drive.enable;
    assign fb_out  = drive.feedback;

endmodule

// File: rtl/olmc_reg_cell_chk.sv
module olmc_reg_cell_chk #(
    parameter int NUM_TERMS = 8,
    parameter int PRELOAD_W = 8,
    parameter int CELL_IDX  = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 comb_sel,
    input logic                 act_high,
    input logic [NUM_TERMS-1:0] pterm,
    input logic                 oe_pin_n,
    input logic                 pin_in,
    input logic                 preload_en,
    input logic [PRELOAD_W-1:0] preload_bus,
    input logic                 pin_out,
    input logic                 pin_oe,
    input logic                 fb_out,
    input logic                 q_state
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (q_state == 1'b0));

    p_capture_sum_r2: assert property (@(posedge clk) disable iff (rst)
        !preload_en |=> (q_state == $past(|pterm)));

    p_polarity_r3: assert property (@(posedge clk) disable iff (rst)
        !comb_sel |-> (pin_out == (act_high ? q_state : !q_state)));

    p_shared_oe_r4: assert property (@(posedge clk) disable iff (rst)
        !comb_sel |-> (pin_oe == !oe_pin_n));

    p_reg_feedback_r5: assert property (@(posedge clk) disable iff (rst)
        !comb_sel |-> (fb_out == q_state));

    p_comb_data_r6: assert property (@(posedge clk) disable iff (rst)
        comb_sel |-> (pin_out == (act_high ? (|pterm[NUM_TERMS-1:1]) : !(|pterm[NUM_TERMS-1:1]))));

    p_term_oe_r7: assert property (@(posedge clk) disable iff (rst)
        comb_sel |-> (pin_oe == pterm[0]));

    p_pin_feedback_r8: assert property (@(posedge clk) disable iff (rst)
        comb_sel |-> (fb_out == pin_in));

    p_preload_r9: assert property (@(posedge clk) disable iff (rst)
        preload_en |=> (q_state == $past(preload_bus[CELL_IDX])));

    p_reset_beats_preload_r10: assert property (@(posedge clk)
        (rst && preload_en) |=> (q_state == 1'b0));

endmodule

bind olmc_reg_cell olmc_reg_cell_chk #(
    .NUM_TERMS (NUM_TERMS),
    .PRELOAD_W (PRELOAD_W),
    .CELL_IDX  (CELL_IDX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .comb_sel    (comb_sel),
    .act_high    (act_high),
    .pterm       (pterm),
    .oe_pin_n    (oe_pin_n),
    .pin_in      (pin_in),
    .preload_en  (preload_en),
    .preload_bus (preload_bus),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out),
    .q_state     (q_state)
);

// File: tb/tb_olmc_reg_cell.sv
module tb_olmc_reg_cell;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int PW = 8;
    localparam int CI = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          comb_sel;
    logic          act_high;
    logic [NT-1:0] pterm;
    logic          oe_pin_n;
    logic          pin_in;
    logic          preload_en;
    logic [PW-1:0] preload_bus;
    logic          pin_out;
    logic          pin_oe;
    logic          fb_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    logic  m_q;
    string last_kind = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    olmc_reg_cell #(.NUM_TERMS(NT), .PRELOAD_W(PW), .CELL_IDX(CI)) dut (
        .clk (clk), .rst (rst), .comb_sel (comb_sel), .act_high (act_high),
        .pterm (pterm), .oe_pin_n (oe_pin_n), .pin_in (pin_in),
        .preload_en (preload_en), .preload_bus (preload_bus),
        .pin_out (pin_out), .pin_oe (pin_oe), .fb_out (fb_out)
    );

    // Behavioural reference of the stored bit
    always @(posedge clk) begin
        if (rst) begin
            m_q <= 1'b0;
            last_kind <= preload_en ? "R10" : "R1";
        end else if (preload_en) begin
            m_q <= preload_bus[CI];
            last_kind <= "R9";
        end else begin
            m_q <= (pterm != '0);
            last_kind <= "R2";
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic s7;
        s7 = (pterm[NT-1:1] != '0);
        if (comb_sel) begin
            check("R6", pin_out, act_high ? s7 : ~s7, "pin_out");
            check("R7", pin_oe, pterm[0], "pin_oe");
            check("R8", fb_out, pin_in, "fb_out");
        end else begin
            check("R3", pin_out, act_high ? m_q : ~m_q, "pin_out");
            check("R4", pin_oe, ~oe_pin_n, "pin_oe");
            check({"R5/", last_kind}, fb_out, m_q, "fb_out");
        end
    endtask

    task automatic apply(input logic r, input logic c, input logic ah, input logic [NT-1:0] pt,
                         input logic oen, input logic pin, input logic pe, input logic [PW-1:0] pb);
        rst = r; comb_sel = c; act_high = ah; pterm = pt;
        oe_pin_n = oen; pin_in = pin; preload_en = pe; preload_bus = pb;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1 and R10: reset, with a preload strobe that must lose
        apply(1, 0, 1, '1, 0, 0, 1, 8'hFF);
        apply(1, 0, 0, '1, 1, 0, 0, 8'hFF);
        apply(0, 0, 1, '0, 0, 0, 0, '0);
        // R2/R3/R4: single-term walk, both polarities, oe pin toggling
        for (int i = 0; i < NT; i++) begin
            apply(0, 0, i[0], NT'(1) << i, i[1], 0, 0, '0);
            apply(0, 0, i[0], '0, ~i[1], 1, 0, '0);
        end
        apply(0, 0, 0, '1, 0, 0, 0, '0);
        apply(0, 0, 1, 8'h01, 1, 0, 0, '0);   // R4: term 0 does not touch pin_oe
        // R9: preload disagreeing with the sum
        apply(0, 0, 1, '1, 0, 0, 1, 8'hF7);
        apply(0, 0, 1, '0, 0, 0, 1, 8'h08);
        apply(0, 0, 0, '0, 0, 0, 1, 8'hF7);
        apply(0, 0, 1, '0, 0, 0, 0, '0);
        // R6/R7/R8: combinational form, term 0 excluded from data
        apply(0, 1, 1, 8'h01, 0, 1, 0, '0);
        apply(0, 1, 0, 8'h01, 1, 0, 0, '0);
        apply(0, 1, 1, 8'h80, 0, 1, 0, '0);
        apply(0, 1, 0, 8'h00, 0, 0, 0, '0);
        for (int i = 0; i < 60; i++)
            apply(0, 1, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 0, '0);
        // R1: reset in the middle of the run after the bit was set
        apply(0, 0, 1, '1, 0, 0, 0, '0);
        apply(1, 0, 1, '1, 0, 0, 0, '0);
        apply(0, 0, 0, '0, 0, 0, 0, '0);
        // Mixed random phase
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 15);
            apply(sel == 0, sel < 5, 1'($urandom), (sel > 9) ? '0 : 8'($urandom),
                  1'($urandom), 1'($urandom), sel == 1 || sel == 7, 8'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule